// File: doc/BRIEF.md
# Issue Queue Readiness-Driven Resize Controller

This controller picks how many chunks of a partitioned instruction issue queue stay powered. The queue is split into equal chunks that can be switched on or off one at a time. The controller watches the per-entry valid and ready flags of the queue and the number of instructions committed each cycle. It does not hold the queue storage or the wakeup logic. A disabled chunk is assumed to be empty.

Over a fixed window of cycles the controller adds up how many enabled chunks were "busy" in each cycle. A chunk is busy when at least half of its live entries are ready to issue. At the window's end, a throughput guard runs first. If the committed-instruction count fell below a fractional share of the previous window's count, the queue grows. Otherwise the busy sum is compared against a low and a high threshold, and the queue shrinks, holds or grows. The chunk-enable mask changes by one chunk at most, and only at a window boundary.

Top module: `iq_resize_ctrl`

## Requirements
- R1: During and right after reset, every chunk is enabled (`chunk_en_o` all ones). Bit i of `chunk_en_o` controls chunk i, and chunk i covers entries i*CHUNK_ENTRIES to i*CHUNK_ENTRIES+CHUNK_ENTRIES-1 of `ready_i`/`valid_i`.
- R2: An entry is counted only when both its `valid_i` and `ready_i` bits are 1. A chunk is busy in a cycle when its counted entries reach CHUNK_ENTRIES/2 or more, so 4 of 8 is busy and 3 of 8 is not.
- R3: A disabled chunk adds nothing to the busy sum, whatever its flags.
- R4: The busy-chunk count of every cycle in a WIN_LEN-cycle window, the last cycle included, is summed. If the guard does not fire and the sum is below `thr_lo_i`, one chunk is disabled.
- R5: If the guard does not fire, a sum with `thr_lo_i` <= sum < `thr_hi_i` keeps the size, and a sum >= `thr_hi_i` enables one more chunk.
- R6: The throughput guard has the highest priority. When present*256 < `dfac_i`*last (present and last are the committed totals of this window and the previous window), one chunk is enabled, whatever the busy sum is.
- R7: In the first window after reset there is no previous count, so the guard never fires there.
- R8: The enabled count stays between 1 and NUM_CHUNKS. A grow at the maximum or a shrink at one leaves the mask unchanged.
- R9: Enabled chunks always form a contiguous run that starts at chunk 0. A shrink disables the highest enabled chunk, and a grow enables the lowest disabled one.
- R10: The mask changes only in the first cycle of a window, by at most one chunk, and it stays constant for the rest of the window.
- R11: At every window boundary the busy sum and the commit total clear to zero, and this window's commit total becomes the "last" value for the next guard check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ready_i | input | NUM_CHUNKS*CHUNK_ENTRIES | Per-entry ready flag |
| valid_i | input | NUM_CHUNKS*CHUNK_ENTRIES | Per-entry valid flag |
| commit_cnt_i | input | CMT_W | Instructions committed this cycle |
| thr_lo_i | input | ACC_W | Lower busy-sum threshold |
| thr_hi_i | input | ACC_W | Upper busy-sum threshold |
| dfac_i | input | DF_W | Degradation factor, value/256 |
| chunk_en_o | output | NUM_CHUNKS | Chunk enable mask |

## Verification
The assertions check every cycle that the mask is a non-empty run of ones that starts at chunk 0, that it is constant inside a window, and that it moves by at most one chunk at a boundary. Which way it moves can only be checked by the bench scenarios. The bench compares the mask with a reference model through the threshold bands and the 3-versus-4 busy boundary. It also covers flags that sit in disabled chunks, the clamps at one chunk and at all chunks, and a throughput drop that overrides a shrink verdict.

// File: rtl/iq_resize_pkg.sv
package iq_resize_pkg;
  typedef enum logic [1:0] {
    RSZ_HOLD   = 2'd0,
    RSZ_GROW   = 2'd1,
    RSZ_SHRINK = 2'd2
  } rsz_op_e;
endpackage

// File: rtl/iq_chunk_activity.sv
module iq_chunk_activity #(
  parameter int NUM_CHUNKS    = 4,
  parameter int CHUNK_ENTRIES = 8,
  parameter int CNT_W         = 3
) (
  input  logic [NUM_CHUNKS*CHUNK_ENTRIES-1:0] ready_i,
  input  logic [NUM_CHUNKS*CHUNK_ENTRIES-1:0] valid_i,
  input  logic [NUM_CHUNKS-1:0]               chunk_en_i,
  output logic [CNT_W-1:0]                    active_cnt_o
);
  localparam int POP_W = $clog2(CHUNK_ENTRIES + 1);
  localparam int HALF  = CHUNK_ENTRIES / 2;

  logic [NUM_CHUNKS-1:0] busy;

  for (genvar c = 0; c < NUM_CHUNKS; c++) begin : g_chunk
    logic [POP_W-1:0] pop;
    always_comb begin
      pop = '0;
      for (int e = 0; e < CHUNK_ENTRIES; e++)
        pop = pop + POP_W'(ready_i[c*CHUNK_ENTRIES+e] & valid_i[c*CHUNK_ENTRIES+e]);
    end
    // disabled chunks never count
    assign busy[c] = chunk_en_i[c] && (pop >= POP_W'(HALF));
  end

  always_comb begin
    active_cnt_o = '0;
    for (int c = 0; c < NUM_CHUNKS; c++)
      active_cnt_o = active_cnt_o + CNT_W'(busy[c]);
  end
endmodule

// File: rtl/iq_window_accum.sv
module iq_window_accum #(
  parameter int WIN_LEN = 1024,
  parameter int CNT_W   = 3,
  parameter int CMT_W   = 3,
  parameter int ACC_W   = 12,
  parameter int IPC_W   = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] active_cnt_i,
  input  logic [CMT_W-1:0] commit_cnt_i,
  output logic             win_end_o,
  output logic [ACC_W-1:0] acc_total_o,
  output logic [IPC_W-1:0] ipc_total_o,
  output logic [IPC_W-1:0] ipc_last_o,
  output logic             last_vld_o
);
  localparam int WC_W = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;

  logic [WC_W-1:0]  win_cnt_q;
  logic [ACC_W-1:0] acc_q;
  logic [IPC_W-1:0] ipc_q;

  assign win_end_o   = (win_cnt_q == WC_W'(WIN_LEN - 1));
  assign acc_total_o = acc_q + ACC_W'(active_cnt_i);
  assign ipc_total_o = ipc_q + IPC_W'(commit_cnt_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_cnt_q  <= '0;
      acc_q      <= '0;
      ipc_q      <= '0;
      ipc_last_o <= '0;
      last_vld_o <= 1'b0;
    end else if (win_end_o) begin
      win_cnt_q  <= '0;
      acc_q      <= '0;
      ipc_q      <= '0;
      ipc_last_o <= ipc_total_o;
      last_vld_o <= 1'b1;
    end else begin
      win_cnt_q  <= win_cnt_q + 1'b1;
      acc_q      <= acc_total_o;
      ipc_q      <= ipc_total_o;
    end
  end
endmodule

// File: rtl/iq_resize_decide.sv
module iq_resize_decide
  import iq_resize_pkg::*;
#(
  parameter int NUM_CHUNKS = 4,
  parameter int ACC_W      = 12,
  parameter int IPC_W      = 13,
  parameter int DF_W       = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  win_end_i,
  input  logic [ACC_W-1:0]      acc_total_i,
  input  logic [IPC_W-1:0]      ipc_total_i,
  input  logic [IPC_W-1:0]      ipc_last_i,
  input  logic                  last_vld_i,
  input  logic [ACC_W-1:0]      thr_lo_i,
  input  logic [ACC_W-1:0]      thr_hi_i,
  input  logic [DF_W-1:0]       dfac_i,
  output logic [NUM_CHUNKS-1:0] chunk_en_o
);
  localparam int EN_W   = $clog2(NUM_CHUNKS + 1);
  localparam int PROD_W = IPC_W + DF_W;

  logic [EN_W-1:0]   n_en_q, n_en_d;
  logic [PROD_W-1:0] ipc_scaled, ipc_floor;
  logic              guard_hit;
  rsz_op_e           op;

  // present*2^DF_W < D*last, no divide
  assign ipc_scaled = PROD_W'(ipc_total_i) << DF_W;
  assign ipc_floor  = PROD_W'(dfac_i) * PROD_W'(ipc_last_i);
  assign guard_hit  = last_vld_i && (ipc_scaled < ipc_floor);

  always_comb begin
    if (guard_hit)                 op = RSZ_GROW;
    else if (acc_total_i < thr_lo_i) op = RSZ_SHRINK;
    else if (acc_total_i < thr_hi_i) op = RSZ_HOLD;
    else                           op = RSZ_GROW;
  end

  always_comb begin
    n_en_d = n_en_q;
    if (win_end_i) begin
      unique case (op)
        RSZ_GROW:   if (n_en_q < EN_W'(NUM_CHUNKS)) n_en_d = n_en_q + 1'b1;
        RSZ_SHRINK: if (n_en_q > EN_W'(1))          n_en_d = n_en_q - 1'b1;
        default:    n_en_d = n_en_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) n_en_q <= EN_W'(NUM_CHUNKS);
    else         n_en_q <= n_en_d;
  end

  for (genvar c = 0; c < NUM_CHUNKS; c++) begin : g_mask
    assign chunk_en_o[c] = (n_en_q > EN_W'(c));
  end
endmodule

// File: rtl/iq_resize_ctrl.sv
module iq_resize_ctrl #(
  parameter int NUM_CHUNKS    = 4,
  parameter int CHUNK_ENTRIES = 8,
  parameter int WIN_LEN       = 1024,
  parameter int CMT_W         = 3,
  parameter int DF_W          = 8,
  localparam int ENTRIES      = NUM_CHUNKS * CHUNK_ENTRIES,
  localparam int ACC_W        = $clog2(WIN_LEN * NUM_CHUNKS + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [ENTRIES-1:0]    ready_i,
  input  logic [ENTRIES-1:0]    valid_i,
  input  logic [CMT_W-1:0]      commit_cnt_i,
  input  logic [ACC_W-1:0]      thr_lo_i,
  input  logic [ACC_W-1:0]      thr_hi_i,
  input  logic [DF_W-1:0]       dfac_i,
  output logic [NUM_CHUNKS-1:0] chunk_en_o
);
  localparam int CNT_W = $clog2(NUM_CHUNKS + 1);
  localparam int IPC_W = $clog2(WIN_LEN * ((1 << CMT_W) - 1) + 1);

  logic [CNT_W-1:0] active_cnt;
  logic             win_end, last_vld;
  logic [ACC_W-1:0] acc_total;
  logic [IPC_W-1:0] ipc_total, ipc_last;

  iq_chunk_activity #(
    .NUM_CHUNKS(NUM_CHUNKS), .CHUNK_ENTRIES(CHUNK_ENTRIES), .CNT_W(CNT_W)
  ) u_act (
    .ready_i(ready_i), .valid_i(valid_i), .chunk_en_i(chunk_en_o),
    .active_cnt_o(active_cnt)
  );

  iq_window_accum #(
    .WIN_LEN(WIN_LEN), .CNT_W(CNT_W), .CMT_W(CMT_W), .ACC_W(ACC_W), .IPC_W(IPC_W)
  ) u_win (
    .clk_i(clk_i), .rst_ni(rst_ni), .active_cnt_i(active_cnt),
    .commit_cnt_i(commit_cnt_i), .win_end_o(win_end), .acc_total_o(acc_total),
    .ipc_total_o(ipc_total), .ipc_last_o(ipc_last), .last_vld_o(last_vld)
  );

  iq_resize_decide #(
    .NUM_CHUNKS(NUM_CHUNKS), .ACC_W(ACC_W), .IPC_W(IPC_W), .DF_W(DF_W)
  ) u_dec (
    .clk_i(clk_i), .rst_ni(rst_ni), .win_end_i(win_end), .acc_total_i(acc_total),
    .ipc_total_i(ipc_total), .ipc_last_i(ipc_last), .last_vld_i(last_vld),
    .thr_lo_i(thr_lo_i), .thr_hi_i(thr_hi_i), .dfac_i(dfac_i),
    .chunk_en_o(chunk_en_o)
  );
endmodule

// File: rtl/iq_resize_chk.sv
module iq_resize_chk #(
  parameter int NUM_CHUNKS = 4,
  parameter int WIN_LEN    = 1024
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [NUM_CHUNKS-1:0] chunk_en_o
);
  localparam int PW = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
  logic [PW-1:0] phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              phase_q <= '0;
    else if (phase_q == PW'(WIN_LEN - 1))     phase_q <= '0;
    else                                      phase_q <= phase_q + 1'b1;
  end

  assert_mask_nonempty_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(chunk_en_o) >= 1);

  assert_mask_contiguous_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((chunk_en_o & (chunk_en_o + NUM_CHUNKS'(1))) == '0));

  assert_mask_held_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q != '0) |-> $stable(chunk_en_o));

  assert_one_step_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == '0) |->
      ((chunk_en_o == $past(chunk_en_o)) ||
       (chunk_en_o == {$past(chunk_en_o[NUM_CHUNKS-2:0]), 1'b1}) ||
       (chunk_en_o == {1'b0, $past(chunk_en_o[NUM_CHUNKS-1:1])})));
endmodule

bind iq_resize_ctrl iq_resize_chk #(
  .NUM_CHUNKS(NUM_CHUNKS), .WIN_LEN(WIN_LEN)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .chunk_en_o(chunk_en_o)
);

// File: tb/sim_iq_resize_ctrl.sv
module sim_iq_resize_ctrl;
  localparam int NC  = 4;
  localparam int CE  = 8;
  localparam int WIN = 32;
  localparam int CW  = 3;
  localparam int ENT = NC * CE;
  localparam int AW  = $clog2(WIN * NC + 1);

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [ENT-1:0] rdy, vld;
  logic [CW-1:0]  cmt;
  logic [AW-1:0]  lo, hi;
  logic [7:0]     df;
  logic [NC-1:0]  en;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  int n_exp = NC, acc_m = 0, ipc_m = 0, last_m = 0;
  bit last_v = 1'b0;
  int cyc = 0, mode = 0, cmt_lvl = 4;
  string tag = "R1";

  always #10 clk = ~clk;

  iq_resize_ctrl #(.NUM_CHUNKS(NC), .CHUNK_ENTRIES(CE), .WIN_LEN(WIN), .CMT_W(CW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ready_i(rdy), .valid_i(vld), .commit_cnt_i(cmt),
    .thr_lo_i(lo), .thr_hi_i(hi), .dfac_i(df), .chunk_en_o(en));

  function automatic logic [NC-1:0] exp_mask(input int n);
    return NC'((1 << n) - 1);
  endfunction

  function automatic int busy_sum(input logic [ENT-1:0] r, input logic [ENT-1:0] v, input int n);
    int s = 0;
    for (int c = 0; c < n; c++) begin
      int p = 0;
      for (int e = 0; e < CE; e++) p += int'(r[c*CE+e] & v[c*CE+e]);
      if (p >= CE/2) s++;
    end
    return s;
  endfunction

  task automatic check_mask(input string t);
    checks++;
    if (en !== exp_mask(n_exp)) begin
      fails++;
      $display("FAIL %s cyc=%0d chunk_en=%b expected=%b", t, cyc, en, exp_mask(n_exp));
    end
  endtask

  task automatic step();
    check_mask({tag, " R9 R10"});
    case (mode)
      0: begin rdy = '1; vld = '1; cmt = CW'(cmt_lvl); end
      1: begin rdy = '0; vld = '1; cmt = CW'(cmt_lvl); end
      2: begin rdy = '0; rdy[3*CE +: CE] = '1; vld = '1; cmt = CW'(cmt_lvl); end
      3: begin
        vld = '1; rdy = '0;
        for (int c = 0; c < NC; c++) rdy[c*CE +: CE] = (c == 0) ? 8'h0F : 8'h07;
        cmt = CW'(cmt_lvl);
      end
      default: begin
        if (cyc % WIN == 0) begin
          lo = AW'($urandom_range(0, 60));
          hi = lo + AW'($urandom_range(0, 60));
          df = 8'($urandom_range(150, 255));
        end
        rdy = $urandom; vld = $urandom | $urandom;
        cmt = CW'($urandom_range(0, 7));
      end
    endcase
    acc_m += busy_sum(rdy, vld, n_exp);
    ipc_m += int'(cmt);
    if (cyc % WIN == WIN - 1) begin
      if (last_v && (ipc_m * 256 < int'(df) * last_m)) begin
        if (n_exp < NC) n_exp++;
      end else if (acc_m < int'(lo)) begin
        if (n_exp > 1) n_exp--;
      end else if (acc_m >= int'(hi)) begin
        if (n_exp < NC) n_exp++;
      end
      last_m = ipc_m; last_v = 1'b1; acc_m = 0; ipc_m = 0;
    end
    cyc++;
    @(negedge clk);
  endtask

  task automatic run(input int nwin, input int m, input string t);
    mode = m; tag = t;
    for (int i = 0; i < nwin * WIN; i++) step();
  endtask

  initial begin
    void'($urandom(32'h1357));
    rdy = '0; vld = '0; cmt = '0; lo = '0; hi = '0; df = '0;
    repeat (3) @(negedge clk);
    check_mask("R1 in reset");
    rst_n = 1'b1;
    check_mask("R1 after reset");
    // no readiness: shrink each window down to one chunk, then clamp
    lo = AW'(10); hi = AW'(100); df = 8'd255; cmt_lvl = 4;
    run(1, 1, "R4 R7");
    run(4, 1, "R4 R8 R11");
    // flags only in a disabled chunk
    lo = AW'(1);
    run(2, 2, "R3");
    // full readiness: grow back and clamp at the top
    lo = AW'(10); hi = AW'(20);
    run(5, 0, "R5 R8");
    // mid band: hold
    hi = AW'(200);
    run(2, 0, "R5 hold");
    // 4-of-8 vs 3-of-8 busy boundary
    lo = AW'(33);
    run(2, 3, "R2");
    // regrow, then a throughput drop that overrides shrink
    lo = AW'(10); hi = AW'(20); cmt_lvl = 4;
    run(3, 0, "R5 regrow");
    lo = AW'(200); hi = AW'(250); df = 8'd128; cmt_lvl = 1;
    run(1, 0, "R6 guard");
    run(1, 0, "R6 R11 steady");
    // random traffic
    run(40, 4, "R2 R11 random");
    check_mask("R10 final");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired, chunk_en=%b expected=%b", en, exp_mask(n_exp));
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule